// File: doc/BRIEF.md
# Byte Lane Mask Unit

This block sits between the command side of a synchronous memory and its 32-bit data path. It turns four raw per-byte mask bits into per-lane write enables and per-lane output enables. A write is masked in the cycle the mask arrives. A read is masked two enabled clocks later, the cycle in which the read data reaches the pins.

Each mask bit affects only the cycle in which it is sampled. Nothing latches or accumulates across cycles.

The clock-enable input freezes the read-mask pipeline and suppresses all write enables while it is low. The read-valid input marks the cycles that carry output data. Outside those cycles the output enables stay inactive, which means high-impedance, whatever the mask says. Both the write enables and the output enables are also offered expanded to one bit per data line.

Top module: `bytemask_unit`

## Requirements
- R1: Lane i covers data bits 8*i+7 down to 8*i, so lane 0 is bits 7..0 and lane 3 is bits 31..24. Every bit of wr_bit_en and rd_bit_oe equals the lane enable of the lane that covers it.
- R2: In a cycle with cke high and wr_phase high, wr_lane_en[i] is the inverse of dq_mask[i] in that same cycle. A mask bit of 1 blocks that byte.
- R3: wr_lane_en is all zero in any cycle where cke is low or wr_phase is low.
- R4: dq_mask is sampled on a rising edge with cke high and wr_phase low. After two further enabled rising edges, rd_lane_oe[i] is the inverse of that sampled bit while rd_valid is high. A 1 means high-impedance.
- R5: Masking does not persist. An unmasked read cycle that follows a masked one enables all lanes two enabled clocks later.
- R6: A mask sampled in a write-phase cycle has no effect on rd_lane_oe two enabled clocks later. All lanes are enabled if rd_valid is high.
- R7: While cke is low, the read-mask pipeline holds its contents, and dq_mask is not sampled.
- R8: While rd_valid is low, rd_lane_oe is all zero.
- R9: An asynchronous active-low reset clears the read-mask pipeline. The first read-valid cycle after reset has all lanes enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low suspends sampling |
| wr_phase | input | 1 | 1 = write cycle, 0 = read cycle |
| dq_mask | input | 4 | Raw per-byte mask, 1 = masked |
| rd_valid | input | 1 | Output data valid in this cycle |
| wr_lane_en | output | 4 | Per-lane write enable |
| wr_bit_en | output | 32 | Write enable expanded per data bit |
| rd_lane_oe | output | 4 | Per-lane output enable, 0 = high-impedance |
| rd_bit_oe | output | 32 | Output enable expanded per data bit |

## Verification
The write gate and the delayed read mask can act in the same cycle. This happens when a write-phase cycle arrives while data from a read two clocks earlier is still being driven out. The stimulus table provokes this by putting a fully masked write directly after masked reads, with rd_valid held high. In that cycle, the write enables are judged against the current mask. The output enables are judged against the mask from two enabled cycles back, and both are checked in the same sample.

// File: rtl/bytemask_pkg.sv
package bytemask_pkg;

  localparam int unsigned LANES_DEF  = 4;
  localparam int unsigned LANE_W_DEF = 8;
  localparam int unsigned RD_LAT_DEF = 2;

  // A lane passes when its gate is open and its mask bit is clear.
  function automatic logic lane_pass(input logic gate, input logic masked);
    return gate & ~masked;
  endfunction

  // Value a read-mask stage captures: write cycles contribute no masking.
  function automatic logic capture_bit(input logic write_cycle, input logic masked);
    return ~write_cycle & masked;
  endfunction

endpackage

// File: rtl/bytemask_wr_gate.sv
module bytemask_wr_gate
  import bytemask_pkg::*;
#(
  parameter int unsigned LANES = LANES_DEF
) (
  input  logic             cke,
  input  logic             wr_phase,
  input  logic [LANES-1:0] mask,
  output logic [LANES-1:0] lane_en
);

  logic wr_open;
  assign wr_open = cke & wr_phase;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_en[g] = lane_pass(wr_open, mask[g]);
  end

endmodule

// File: rtl/bytemask_rd_pipe.sv
module bytemask_rd_pipe
  import bytemask_pkg::*;
#(
  parameter int unsigned LANES = LANES_DEF,
  parameter int unsigned DEPTH = RD_LAT_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             wr_phase,
  input  logic [LANES-1:0] mask,
  output logic [LANES-1:0] capture,
  output logic [LANES-1:0] pipe_out
);

  logic [LANES-1:0] stage_q [DEPTH];

  for (genvar l = 0; l < LANES; l++) begin : g_cap
    assign capture[l] = capture_bit(wr_phase, mask[l]);
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic [LANES-1:0] stage_d;
    if (s == 0) begin : g_head
      assign stage_d = capture;
    end else begin : g_body
      assign stage_d = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else if (cke) begin
        stage_q[s] <= stage_d;
      end
    end
  end

  assign pipe_out = stage_q[DEPTH-1];

endmodule

// File: rtl/bytemask_lane_expand.sv
module bytemask_lane_expand
  import bytemask_pkg::*;
#(
  parameter int unsigned LANES  = LANES_DEF,
  parameter int unsigned LANE_W = LANE_W_DEF,
  localparam int unsigned BITS  = LANES * LANE_W
) (
  input  logic [LANES-1:0] lane_in,
  output logic [BITS-1:0]  bit_out
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bit_out[g*LANE_W +: LANE_W] = {LANE_W{lane_in[g]}};
  end

endmodule

// File: rtl/bytemask_unit.sv
module bytemask_unit
  import bytemask_pkg::*;
#(
  parameter int unsigned LANES  = LANES_DEF,
  parameter int unsigned LANE_W = LANE_W_DEF,
  parameter int unsigned RD_LAT = RD_LAT_DEF,
  localparam int unsigned BITS  = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             wr_phase,
  input  logic [LANES-1:0] dq_mask,
  input  logic             rd_valid,
  output logic [LANES-1:0] wr_lane_en,
  output logic [BITS-1:0]  wr_bit_en,
  output logic [LANES-1:0] rd_lane_oe,
  output logic [BITS-1:0]  rd_bit_oe
);

  // Named internal events, visible to the bound checker.
  logic [LANES-1:0] rd_capture;
  logic [LANES-1:0] rd_mask_due;

  bytemask_wr_gate #(.LANES(LANES)) u_wr_gate (
    .cke      (cke),
    .wr_phase (wr_phase),
    .mask     (dq_mask),
    .lane_en  (wr_lane_en)
  );

  bytemask_rd_pipe #(.LANES(LANES), .DEPTH(RD_LAT)) u_rd_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .wr_phase (wr_phase),
    .mask     (dq_mask),
    .capture  (rd_capture),
    .pipe_out (rd_mask_due)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_oe
    assign rd_lane_oe[g] = lane_pass(rd_valid, rd_mask_due[g]);
  end

  bytemask_lane_expand #(.LANES(LANES), .LANE_W(LANE_W)) u_wr_expand (
    .lane_in (wr_lane_en),
    .bit_out (wr_bit_en)
  );

  bytemask_lane_expand #(.LANES(LANES), .LANE_W(LANE_W)) u_rd_expand (
    .lane_in (rd_lane_oe),
    .bit_out (rd_bit_oe)
  );

endmodule

// File: rtl/bytemask_unit_chk.sv
module bytemask_unit_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned RD_LAT = 2,
  localparam int unsigned BITS  = LANES * LANE_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke,
  input logic             wr_phase,
  input logic [LANES-1:0] dq_mask,
  input logic             rd_valid,
  input logic [LANES-1:0] wr_lane_en,
  input logic [BITS-1:0]  wr_bit_en,
  input logic [LANES-1:0] rd_lane_oe,
  input logic [BITS-1:0]  rd_bit_oe,
  input logic [LANES-1:0] rd_mask_due
);

  logic [1:0] edges_since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edges_since_rst <= '0;
    else if (edges_since_rst != 2'd3) edges_since_rst <= edges_since_rst + 2'd1;
  end

  // R2
  wr_follows_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && wr_phase) |-> (wr_lane_en == ~dq_mask));

  // R3
  wr_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cke && wr_phase) |-> (wr_lane_en == '0));

  // R4
  rd_mask_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (RD_LAT == 2 && edges_since_rst == 2'd3 && $past(cke, 1) && $past(cke, 2)
     && !$past(wr_phase, 2) && rd_valid) |-> (rd_lane_oe == ~$past(dq_mask, 2)));

  // R6
  wr_mask_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (RD_LAT == 2 && edges_since_rst == 2'd3 && $past(cke, 1) && $past(cke, 2)
     && $past(wr_phase, 2) && rd_valid) |-> (rd_lane_oe == {LANES{1'b1}}));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edges_since_rst != 2'd0 && !$past(cke)) |-> $stable(rd_mask_due));

  // R8
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_lane_oe == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_map
    // R1
    lane_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_bit_en[g*LANE_W +: LANE_W] == {LANE_W{wr_lane_en[g]}})
      && (rd_bit_oe[g*LANE_W +: LANE_W] == {LANE_W{rd_lane_oe[g]}}));
  end

endmodule

bind bytemask_unit bytemask_unit_chk #(
  .LANES(LANES), .LANE_W(LANE_W), .RD_LAT(RD_LAT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cke         (cke),
  .wr_phase    (wr_phase),
  .dq_mask     (dq_mask),
  .rd_valid    (rd_valid),
  .wr_lane_en  (wr_lane_en),
  .wr_bit_en   (wr_bit_en),
  .rd_lane_oe  (rd_lane_oe),
  .rd_bit_oe   (rd_bit_oe),
  .rd_mask_due (rd_mask_due)
);

// File: tb/tb_bytemask_unit.sv
module tb_bytemask_unit;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b0;
  logic        wr_phase = 1'b0;
  logic [3:0]  dq_mask = 4'h0;
  logic        rd_valid = 1'b0;
  logic [3:0]  wr_lane_en;
  logic [31:0] wr_bit_en;
  logic [3:0]  rd_lane_oe;
  logic [31:0] rd_bit_oe;

  int checks = 0;
  int errors = 0;

  // Bench view of the read masks still in flight (newest, oldest).
  logic [3:0] m_new = 4'h0;
  logic [3:0] m_old = 4'h0;

  always #(CLK_P/2) clk = ~clk;

  bytemask_unit dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .wr_phase(wr_phase),
    .dq_mask(dq_mask), .rd_valid(rd_valid), .wr_lane_en(wr_lane_en),
    .wr_bit_en(wr_bit_en), .rd_lane_oe(rd_lane_oe), .rd_bit_oe(rd_bit_oe)
  );

  // Fields: [10] cke, [9] write phase, [8:5] mask, [4] read valid, [3:0] expected write lanes
  localparam logic [10:0] VEC [16] = '{
    11'b1_1_0000_0_1111, 11'b1_1_0101_0_1010, 11'b1_0_0011_0_0000, 11'b1_0_1100_0_0000,
    11'b1_0_0000_1_0000, 11'b1_0_1001_1_0000, 11'b1_1_1111_1_0000, 11'b1_1_0110_0_1001,
    11'b0_1_0000_0_0000, 11'b1_0_0001_1_0000, 11'b1_0_1000_1_0000, 11'b0_0_0100_1_0000,
    11'b0_0_0010_1_0000, 11'b1_0_0000_1_0000, 11'b1_0_0000_1_0000, 11'b1_1_1010_1_0101
  };

  task automatic check4(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_bits(input string tag);
    logic ok = 1'b1;
    for (int b = 0; b < 32; b++) begin
      if (wr_bit_en[b] !== wr_lane_en[b/8] || rd_bit_oe[b] !== rd_lane_oe[b/8]) ok = 1'b0;
    end
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual wr %h oe %h expected lanes wr %b oe %b",
               tag, wr_bit_en, rd_bit_oe, wr_lane_en, rd_lane_oe);
    end
  endtask

  // Drive one cycle, check outputs, then account for the next rising edge.
  task automatic step(input logic c, input logic w, input logic [3:0] m, input logic r,
                      input string oe_tag);
    logic [3:0] exp_wr;
    logic [3:0] exp_oe;
    @(negedge clk);
    cke = c; wr_phase = w; dq_mask = m; rd_valid = r;
    #1;
    exp_wr = (c && w) ? ~m : 4'h0;
    exp_oe = r ? ~m_old : 4'h0;
    check4(wr_lane_en, exp_wr, (c && w) ? "R2 write lanes" : "R3 write closed");
    check4(rd_lane_oe, exp_oe, oe_tag);
    check_bits("R1 lane map");
    if (c) begin
      m_old = m_new;
      m_new = w ? 4'h0 : m;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: cleared pipeline right after reset
    step(1'b1, 1'b0, 4'h0, 1'b1, "R9 after reset");

    // Table walk: write gating checked against table, read enables against history (R4, R8)
    for (int i = 0; i < 16; i++) begin
      logic [10:0] v = VEC[i];
      step(v[10], v[9], v[8:5], v[4], "R4 read enables");
      check4(wr_lane_en, v[3:0], "R2 table write lanes");
    end

    // R5: masked read followed by unmasked reads
    step(1'b1, 1'b0, 4'hF, 1'b0, "R8 idle");
    step(1'b1, 1'b0, 4'h0, 1'b0, "R8 idle");
    step(1'b1, 1'b0, 4'h0, 1'b1, "R5 masked read");
    check4(rd_lane_oe, 4'h0, "R4 full mask two clocks later");
    step(1'b1, 1'b0, 4'h0, 1'b1, "R5 mask released");
    check4(rd_lane_oe, 4'hF, "R5 no persistence");

    // R6: mask in write cycle must not blank outputs
    step(1'b1, 1'b1, 4'hF, 1'b0, "R8 idle");
    step(1'b1, 1'b0, 4'h0, 1'b0, "R8 idle");
    step(1'b1, 1'b0, 4'h0, 1'b1, "R6 write mask ignored");
    check4(rd_lane_oe, 4'hF, "R6 all lanes enabled");

    // R7: stall holds the pipeline and ignores mask
    step(1'b1, 1'b0, 4'h6, 1'b0, "R8 idle");
    step(1'b0, 1'b0, 4'hF, 1'b1, "R7 stall");
    step(1'b0, 1'b1, 4'h9, 1'b1, "R7 stall");
    step(1'b1, 1'b0, 4'h0, 1'b1, "R7 resume");
    step(1'b1, 1'b0, 4'h0, 1'b1, "R7 held mask emerges");
    check4(rd_lane_oe, 4'h9, "R7 held mask value");

    // R9: reset mid-flight discards queued masks
    step(1'b1, 1'b0, 4'hF, 1'b0, "R8 idle");
    step(1'b1, 1'b0, 4'hF, 1'b0, "R8 idle");
    @(negedge clk);
    rst_n = 1'b0;
    m_new = 4'h0; m_old = 4'h0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 4'h0, 1'b1, "R9 pipeline cleared");
    check4(rd_lane_oe, 4'hF, "R9 first read unmasked");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule